// File: doc/BRIEF.md
# Polyphase FIR Decimator

This block lowers the sample rate of a real, fixed-point stream by an integer factor M while low-pass filtering it with a fixed prototype FIR of length N. The prototype is never run at the input rate. Its taps are dealt out by phase into M branches. A rotating pointer hands each accepted input to one branch, and every branch shifts its own short delay line only when it is handed a sample. Once a group of M samples is complete, the branch dot products are added, rounded and clamped to give one output. No output sample that would later be dropped is ever computed.

The prototype is triangular and symmetric: tap k has the value STEP·(min(k, N−1−k)+1), and it is zero beyond N−1 when N is not a multiple of M. Inputs arrive with a valid/ready handshake at the high rate. Outputs leave as a one-cycle valid pulse at the reduced rate.

A three-state sequencer tracks each group:
- `ST_IDLE`: no sample of the current group has been taken.
- `ST_FILL`: the group is partly filled.
- `ST_DONE`: lasts one cycle, after the sample that closes the group.

Its transitions are:
- IDLE goes to FILL on an accepted sample.
- FILL goes to DONE when the sample for branch 0 is accepted.
- DONE goes to FILL on an accepted sample, or to IDLE without one.

Top module: `pfd_decimator`

## Requirements
- R1: Branch p multiplies its j-th newest sample by prototype tap p+j·M. Tap k equals 1024·(min(k, N−1−k)+1) with the defaults N=16 and M=4. Taps at k≥N read as zero.
- R2: After reset, the first accepted sample goes to branch M−1. Each later sample goes to the next lower branch index, and the pointer wraps from branch 0 back to M−1.
- R3: Exactly one output is produced per M accepted samples. out_valid is high for one cycle: the cycle after the clock edge that follows the edge accepting the branch-0 sample.
- R4: Output g, counting from 0 since reset, equals Σ_k h[k]·x[g·M+M−1−k], with x the accepted samples since reset and x at a negative index taken as zero.
- R5: A sample is accepted only on an edge where in_valid and in_ready are both high. Otherwise the pointer, the delay lines and the outputs keep their values, whatever in_data carries.
- R6: Synchronous reset clears every delay line, returns the pointer to branch M−1, clears out_valid and out_data, and holds in_ready low while asserted.
- R7: Products are summed at full precision. The sum is then rounded at bit SHIFT=15 with halves going toward +∞, and clamped to the range 32767 … −32768.
- R8: out_data keeps the value of the last output until the next out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample (low during reset) |
| in_data | input | DW (16) | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_data | output | OW (16) | Signed, rounded and saturated output |

## Verification
On every cycle, the assertions follow the pointer's downward rotation and its hold during stalls. They also confirm that a delay line stays frozen when its branch is not loaded, that each output pulse comes exactly two edges after a group closes, that out_data holds between pulses, and that rounding never flips the sign of the sum.

Only the bench scenarios can show the numbers themselves: which tap meets which sample, bit-exact agreement with a direct-form filter followed by keep-one-in-M, clamping at both rails, ties rounding upward, and the full restart of the filter state after a reset taken in the middle of a group.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DONE
    } phase_t;

    // Symmetric triangular prototype, zero beyond its length (padding).
    function automatic int proto_coef(input int k, input int n, input int step);
        int mirror;
        if (k >= n) begin
            return 0;
        end
        mirror = (k < n - 1 - k) ? k : n - 1 - k;
        return step * (mirror + 1);
    endfunction

endpackage

// File: rtl/pfd_commutator.sv
module pfd_commutator
    import pfd_pkg::*;
#(
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    output logic         accept,
    output logic [M-1:0] load,
    output logic         close,
    output logic         emit
);

    localparam int PW = (M > 1) ? $clog2(M) : 1;
    localparam logic [PW-1:0] LAST = PW'(M - 1);

    phase_t        state;
    phase_t        state_nxt;
    logic [PW-1:0] ptr;
    logic          at_zero;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // branch pointer, counts downward and wraps
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= LAST;
        end else if (accept) begin
            ptr <= at_zero ? LAST : ptr - 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept) state_nxt = at_zero ? ST_DONE : ST_FILL;
            ST_FILL: if (accept && at_zero) state_nxt = ST_DONE;
            ST_DONE: state_nxt = accept ? (at_zero ? ST_DONE : ST_FILL) : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        at_zero  = (ptr == '0);
        in_ready = !rst;
        accept   = in_valid && in_ready;
        close    = accept && at_zero;
        emit     = (state == ST_DONE);
        load     = '0;
        if (accept) begin
            load[ptr] = 1'b1;
        end
    end

    p_rotate_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> ptr == (($past(ptr) == '0) ? LAST : $past(ptr) - 1'b1));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(ptr));

endmodule

// File: rtl/pfd_branch.sv
module pfd_branch
    import pfd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int M    = 4,
    parameter int N    = 16,
    parameter int K    = 4,
    parameter int P    = 0,
    parameter int STEP = 1024,
    parameter int BW   = DW + CW + $clog2(K) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [DW-1:0] sample,
    output logic signed [BW-1:0] dot
);

    localparam int PRW = DW + CW;

    logic signed [DW-1:0]  taps [K];
    logic signed [PRW-1:0] prod [K];

    // delay line, shifts only on samples routed to this branch
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < K; j++) begin
                taps[j] <= '0;
            end
        end else if (load) begin
            taps[0] <= sample;
            for (int j = 1; j < K; j++) begin
                taps[j] <= taps[j-1];
            end
        end
    end

    for (genvar j = 0; j < K; j++) begin : g_tap
        localparam logic signed [CW-1:0] COEF = CW'(proto_coef(P + j * M, N, STEP));
        assign prod[j] = PRW'(taps[j]) * PRW'(COEF);
    end

    always_comb begin
        dot = '0;
        for (int j = 0; j < K; j++) begin
            dot = dot + BW'(prod[j]);
        end
    end

    p_line_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(taps[0]) && $stable(taps[K-1]));

endmodule

// File: rtl/pfd_round_sat.sv
module pfd_round_sat #(
    parameter int AW    = 37,
    parameter int OW    = 16,
    parameter int SHIFT = 15
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [OW-1:0] y
);

    localparam logic signed [AW:0] HALF =
        {{(AW - SHIFT + 1){1'b0}}, 1'b1, {(SHIFT - 1){1'b0}}};
    localparam logic signed [AW:0] MAXV = {{(AW - OW + 2){1'b0}}, {(OW - 1){1'b1}}};
    localparam logic signed [AW:0] MINV = {{(AW - OW + 2){1'b1}}, {(OW - 1){1'b0}}};

    logic signed [AW:0] biased;
    logic signed [AW:0] shifted;

    always_comb begin
        biased  = $signed({acc[AW-1], acc}) + HALF;
        shifted = biased >>> SHIFT;
        if (shifted > MAXV) begin
            y = MAXV[OW-1:0];
        end else if (shifted < MINV) begin
            y = MINV[OW-1:0];
        end else begin
            y = shifted[OW-1:0];
        end
        p_sign_keep_r7: assert ((acc >= 0) ? (y >= 0) : (y <= 0));
    end

endmodule

// File: rtl/pfd_decimator.sv
module pfd_decimator
    import pfd_pkg::*;
#(
    parameter int M     = 4,
    parameter int N     = 16,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int OW    = 16,
    parameter int SHIFT = 15,
    parameter int STEP  = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data
);

    localparam int K  = (N + M - 1) / M;
    localparam int BW = DW + CW + $clog2(K) + 1;
    localparam int AW = DW + CW + $clog2(K * M) + 1;

    logic                 accept;
    logic [M-1:0]         load;
    logic                 close_w;
    logic                 emit;
    logic signed [BW-1:0] dots [M];
    logic signed [AW-1:0] total;
    logic signed [OW-1:0] rounded;

    pfd_commutator #(.M(M)) u_comm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept),
        .load     (load),
        .close    (close_w),
        .emit     (emit)
    );

    for (genvar p = 0; p < M; p++) begin : g_branch
        pfd_branch #(
            .DW(DW), .CW(CW), .M(M), .N(N), .K(K), .P(p), .STEP(STEP), .BW(BW)
        ) u_br (
            .clk    (clk),
            .rst    (rst),
            .load   (load[p]),
            .sample (in_data),
            .dot    (dots[p])
        );
    end

    always_comb begin
        total = '0;
        for (int p = 0; p < M; p++) begin
            total = total + AW'(dots[p]);
        end
    end

    pfd_round_sat #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_rs (
        .acc (total),
        .y   (rounded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data <= rounded;
            end
        end
    end

    p_pulse_timing_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(close_w, 2));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // unused handshake copy kept for clarity of the accept path
    logic unused_ok;
    assign unused_ok = accept;

endmodule

// File: tb/sim_pfd_decimator.sv
`timescale 1ns/1ps
module sim_pfd_decimator;

    localparam int M = 4, N = 16, SHIFT = 15, STEP = 1024;
    localparam int NV = 24;
    localparam int VEC [NV] = '{1200, -3400, 5600, 32767, -32768, 77, 0, -1,
                                250, 9000, -9000, 12345, -23456, 31000, -31000, 4,
                                8, 15, 16, -16, -17, 2000, -2000, 100};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic in_ready;
    logic out_valid;
    logic signed [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    longint xh [512];
    longint yv [64];
    int nx = 0;
    int ny = 0;

    always #2.5 clk = ~clk;

    pfd_decimator u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint hc(int k);
        int m;
        if (k >= N) return 0;
        m = (k < N - 1 - k) ? k : N - 1 - k;
        return longint'(STEP * (m + 1));
    endfunction

    function automatic longint ref_y(int g);
        longint acc = 0;
        longint r;
        for (int k = 0; k < N; k++) begin
            int idx = g * M + M - 1 - k;
            if (idx >= 0) acc += hc(k) * xh[idx];
        end
        r = (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // output monitor: every output against the direct-form reference (R4)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            check("R4 output value", out_data, ref_y(ny));
            if (ny < 64) yv[ny] = out_data;
            ny++;
        end
    end

    task automatic push(input int v);
        in_valid = 1'b1;
        in_data  = 16'(v);
        xh[nx]   = v;
        nx++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        nx = 0;
        ny = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        check("R3 output count", ny, nx / M);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        longint hold_v;
        // reset state (R6)
        repeat (3) @(negedge clk);
        check("R6 in_ready low in reset", in_ready, 0);
        check("R6 out_valid low in reset", out_valid, 0);
        check("R6 out_data cleared", out_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 in_ready after reset", in_ready, 1);

        // vector table walk with bubbles (R4, R2, R5)
        for (int i = 0; i < NV; i++) begin
            push(VEC[i]);
            if (i % 5 == 2) repeat (2) @(negedge clk);
        end
        drain();

        // pulse timing and output hold (R3, R8)
        do_reset();
        push(3); push(4); push(5);
        in_valid = 1'b1; in_data = 16'sd16384; xh[nx] = 16384; nx++;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 no pulse one edge after close", out_valid, 0);
        @(negedge clk);
        check("R3 pulse two edges after close", out_valid, 1);
        hold_v = out_data;
        @(negedge clk);
        check("R3 pulse lasts one cycle", out_valid, 0);
        repeat (3) @(negedge clk);
        check("R8 out_data held", out_data, hold_v);

        // impulse in first slot: first sample meets tap M-1 (R1, R2)
        do_reset();
        push(16384);
        for (int i = 0; i < 15; i++) push(0);
        drain();
        check("R1 impulse slot0 y0", yv[0], 2048);
        check("R1 impulse slot0 y1", yv[1], 4096);
        check("R2 impulse slot0 y2", yv[2], 2560);
        check("R2 impulse slot0 y3", yv[3], 512);

        // impulse in last slot: taps 0, M, 2M, 3M
        do_reset();
        push(0); push(0); push(0); push(16384);
        for (int i = 0; i < 12; i++) push(0);
        drain();
        check("R1 impulse slot3 y0", yv[0], 512);
        check("R1 impulse slot3 y1", yv[1], 2560);
        check("R1 impulse slot3 y2", yv[2], 4096);
        check("R1 impulse slot3 y3", yv[3], 2048);

        // saturation at both rails (R7)
        do_reset();
        for (int i = 0; i < 16; i++) push(32767);
        for (int i = 0; i < 16; i++) push(-32768);
        drain();
        check("R7 positive clamp", yv[3], 32767);
        check("R7 negative clamp", yv[7], -32768);

        // rounding ties toward +inf (R7)
        do_reset();
        push(0); push(0); push(0); push(16);
        drain();
        check("R7 tie +0.5 rounds up", yv[0], 1);
        do_reset();
        push(0); push(0); push(0); push(-16);
        drain();
        check("R7 tie -0.5 rounds up", yv[0], 0);
        do_reset();
        push(0); push(0); push(0); push(-17);
        drain();
        check("R7 below -0.5 rounds down", yv[0], -1);

        // stall with changing data is ignored (R5)
        do_reset();
        push(1000); push(-2000);
        for (int i = 0; i < 10; i++) begin
            in_data = 16'(i * 3001);
            @(negedge clk);
        end
        check("R5 no output during stall", ny, 0);
        push(3000); push(4000);
        drain();
        check("R5 one output after stall", ny, 1);

        // reset in the middle of a group restarts everything (R6)
        do_reset();
        push(30000); push(30000);
        do_reset();
        push(0); push(0); push(0); push(16384);
        drain();
        check("R6 mid-group reset clears state", yv[0], 512);

        summary();
        $finish;
    end

endmodule